// File: doc/BRIEF.md
# Retransmission Timer and Limiter

This block watches the single unacknowledged segment of a reliable link transmitter. A sent-segment pulse starts a timeout counter that advances only on an external unit tick, which a shared prescaler supplies. If the counter reaches the programmed timeout before an acknowledgment arrives, the block raises a one-cycle resend request and starts timing again.

The block keeps a per-segment retry count against a programmable budget. When the budget is used up and the timer expires once more, the block sets a sticky broken-connection flag instead of asking for another resend. A 32-bit statistic counts every resend the current connection has requested. An open-connection request clears the flag, the statistic and all timing state, so a new connection starts clean.

Top module: `retx_guard`

## Requirements
- R1: After reset `resend_o` is 0, `broken_o` is 0 and `resend_total_o` is 0, and no segment is being timed.
- R2: Ticks and acknowledgments while no segment is being timed have no effect: `resend_o` stays 0 and `resend_total_o` is unchanged.
- R3: When `seg_sent_i` arms the timer, the tick that is the `timeout_i`-th after arming (timeout 0 acts as 1) expires it. If retries remain, `resend_o` is 1 for the one cycle after that tick's clock edge, and the count restarts from zero.
- R4: `ack_rcvd_i` stops the timer and clears the per-segment retry count. An acknowledgment or a sent pulse in the same cycle as an expiring tick suppresses that resend.
- R5: An expiry with retry count equal to or above `max_retry_i` sets `broken_o` in the following cycle and gives no resend, so with budget N exactly N resends come before the failure. Budget 0 fails on the first expiry.
- R6: While `broken_o` is 1, sent pulses, acknowledgments and ticks are ignored, `resend_o` stays 0 and the flag holds until an open request.
- R7: `resend_total_o` grows by exactly one per resend request, wraps modulo 2^32, and is cleared only by an open request.
- R8: `open_req_i` has priority over all other inputs. In the next cycle the broken flag, the statistic, the retry count and the timer are all clear, and the timer stays idle until a new sent pulse.
- R9: A sent pulse while a segment is already being timed restarts the count from zero and clears the retry count, and no resend is requested in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_req_i | input | 1 | New connection request, clears all state |
| seg_sent_i | input | 1 | A segment was transmitted, start timing it |
| ack_rcvd_i | input | 1 | The outstanding segment was acknowledged |
| unit_tick_i | input | 1 | One timeout unit has elapsed |
| timeout_i | input | 16 | Timeout in units |
| max_retry_i | input | 8 | Resends allowed per segment |
| resend_o | output | 1 | One-cycle resend request |
| broken_o | output | 1 | Sticky retry-budget-exhausted flag |
| resend_total_o | output | 32 | Resends requested in this connection |

## Verification
Ticks with nothing armed show that the timer only runs for a real segment. Uninterrupted tick streams at several timeouts, including 0 and 1, separate an off-by-one in expiry from a correct count. Streams interrupted by acknowledgments, restarting sent pulses and same-cycle collisions separate retry-count clearing from retry-count carrying. Budgets of 0, 1 and 2 run to exhaustion and then face sent pulses and ticks, which shows the failure point and the stickiness of the flag. A long mixed stream with occasional open requests is compared cycle by cycle against a behavioural model.

// File: rtl/retx_pkg.sv
package retx_pkg;
  localparam int unsigned TOUT_W_DEF  = 16;
  localparam int unsigned RETRY_W_DEF = 8;
  localparam int unsigned STAT_W_DEF  = 32;

  // outcome of one timer expiry
  typedef enum logic [1:0] {
    VERD_NONE   = 2'd0,
    VERD_RESEND = 2'd1,
    VERD_FAIL   = 2'd2
  } verdict_e;
endpackage

// File: rtl/retx_timer.sv
module retx_timer #(
  parameter int unsigned TOUT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,   // open request
  input  logic              arm_i,     // new segment
  input  logic              stop_i,    // acknowledgment
  input  logic              tick_i,
  input  logic [TOUT_W-1:0] timeout_i,
  input  logic              halt_i,    // budget exhausted: disarm on expiry
  output logic              expire_o
);
  localparam int unsigned CW = TOUT_W + 1;

  logic              armed_q, armed_d;
  logic [TOUT_W-1:0] cnt_q, cnt_d;
  logic [CW-1:0]     cnt_inc;
  logic              reach;
  logic              en;

  always_comb begin
    cnt_inc  = {1'b0, cnt_q} + {{(CW-1){1'b0}}, 1'b1};
    reach    = cnt_inc >= {1'b0, timeout_i};
    expire_o = armed_q & tick_i & ~clear_i & ~arm_i & ~stop_i & reach;
  end

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    en      = clear_i | arm_i | stop_i | (armed_q & tick_i);
    if (clear_i) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (arm_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (stop_i) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (armed_q && tick_i) begin
      if (reach) begin
        armed_d = ~halt_i;
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt_inc[TOUT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (en) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  // a non-expiring tick advances the count by one
  assert_tick_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && tick_i && !clear_i && !arm_i && !stop_i && !reach)
      |=> (cnt_q == $past(cnt_q) + 1'b1));

  // failing expiry leaves the timer idle
  assert_fail_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && halt_i) |=> !armed_q);

  // open request leaves the timer idle
  assert_open_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!armed_q && cnt_q == '0));
endmodule

// File: rtl/retx_budget.sv
module retx_budget
  import retx_pkg::*;
#(
  parameter int unsigned RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               new_seg_i,  // sent or ack: retries start over
  input  logic               expire_i,
  input  logic [RETRY_W-1:0] max_retry_i,
  output logic               halt_o,
  output logic               bump_o,
  output logic               resend_o,
  output logic               broken_o
);
  logic [RETRY_W-1:0] retries_q, retries_d;
  logic               broken_q, broken_d;
  logic               resend_q, resend_d;
  verdict_e           verdict;
  logic               en;

  always_comb begin
    halt_o = retries_q >= max_retry_i;
    if (!expire_i)   verdict = VERD_NONE;
    else if (halt_o) verdict = VERD_FAIL;
    else             verdict = VERD_RESEND;
    bump_o = (verdict == VERD_RESEND);
  end

  always_comb begin
    retries_d = retries_q;
    broken_d  = broken_q;
    resend_d  = 1'b0;
    en        = clear_i | new_seg_i | expire_i;
    if (clear_i) begin
      retries_d = '0;
      broken_d  = 1'b0;
    end else if (!broken_q) begin
      if (new_seg_i) begin
        retries_d = '0;
      end else begin
        unique case (verdict)
          VERD_RESEND: begin
            retries_d = retries_q + 1'b1;
            resend_d  = 1'b1;
          end
          VERD_FAIL: broken_d = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retries_q <= '0;
      broken_q  <= 1'b0;
    end else if (en) begin
      retries_q <= retries_d;
      broken_q  <= broken_d;
    end
  end

  // pulse register loads every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resend_q <= 1'b0;
    else        resend_q <= resend_d;
  end

  assign resend_o = resend_q;
  assign broken_o = broken_q;

  assert_broken_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (broken_q && !clear_i) |=> broken_q);

  assert_no_resend_when_broken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    broken_q |=> !resend_q);

  assert_ack_clears_retries_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (new_seg_i && !broken_q) |=> (retries_q == '0));
endmodule

// File: rtl/retx_stat.sv
module retx_stat #(
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              bump_i,
  output logic [STAT_W-1:0] total_o
);
  logic [STAT_W-1:0] total_q, total_d;
  logic              en;

  always_comb begin
    en      = clear_i | bump_i;
    total_d = clear_i ? '0 : total_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  total_q <= '0;
    else if (en) total_q <= total_d;
  end

  assign total_o = total_q;

  assert_stat_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bump_i && !clear_i) |=> (total_q == $past(total_q) + 1'b1));

  assert_stat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bump_i && !clear_i) |=> $stable(total_q));

  assert_stat_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (total_q == '0));
endmodule

// File: rtl/retx_guard.sv
module retx_guard
  import retx_pkg::*;
#(
  parameter int unsigned TOUT_W  = TOUT_W_DEF,
  parameter int unsigned RETRY_W = RETRY_W_DEF,
  parameter int unsigned STAT_W  = STAT_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               open_req_i,
  input  logic               seg_sent_i,
  input  logic               ack_rcvd_i,
  input  logic               unit_tick_i,
  input  logic [TOUT_W-1:0]  timeout_i,
  input  logic [RETRY_W-1:0] max_retry_i,
  output logic               resend_o,
  output logic               broken_o,
  output logic [STAT_W-1:0]  resend_total_o
);
  logic sent_g, ack_g;
  logic expire, halt, bump;

  // a broken link ignores segment traffic until reopened
  assign sent_g = seg_sent_i & ~broken_o;
  assign ack_g  = ack_rcvd_i & ~broken_o;

  retx_timer #(.TOUT_W(TOUT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (open_req_i),
    .arm_i     (sent_g),
    .stop_i    (ack_g),
    .tick_i    (unit_tick_i),
    .timeout_i (timeout_i),
    .halt_i    (halt),
    .expire_o  (expire)
  );

  retx_budget #(.RETRY_W(RETRY_W)) u_budget (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (open_req_i),
    .new_seg_i   (sent_g | ack_g),
    .expire_i    (expire),
    .max_retry_i (max_retry_i),
    .halt_o      (halt),
    .bump_o      (bump),
    .resend_o    (resend_o),
    .broken_o    (broken_o)
  );

  retx_stat #(.STAT_W(STAT_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (open_req_i),
    .bump_i  (bump),
    .total_o (resend_total_o)
  );

  assert_sent_no_resend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_sent_i && !open_req_i) |=> !resend_o);

  assert_resend_counted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resend_o && !$past(open_req_i)) |-> (resend_total_o != '0));

  assert_open_clears_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    open_req_i |=> (!broken_o && !resend_o));
endmodule

// File: tb/tb_retx_guard.sv
module tb_retx_guard;
  logic        clk;
  logic        rst_n;
  logic        open_req, seg_sent, ack_rcvd, unit_tick;
  logic [15:0] timeout;
  logic [7:0]  max_retry;
  logic        resend;
  logic        broken;
  logic [31:0] total;

  int checks;
  int fails;
  bit done;

  retx_guard dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .open_req_i     (open_req),
    .seg_sent_i     (seg_sent),
    .ack_rcvd_i     (ack_rcvd),
    .unit_tick_i    (unit_tick),
    .timeout_i      (timeout),
    .max_retry_i    (max_retry),
    .resend_o       (resend),
    .broken_o       (broken),
    .resend_total_o (total)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference model
  bit          m_armed, m_broken, m_resend;
  int          m_cnt, m_retries;
  logic [31:0] m_total;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; m_broken = 0; m_resend = 0;
      m_cnt = 0; m_retries = 0; m_total = '0;
    end else begin
      m_resend = 0;
      if (open_req) begin
        m_armed = 0; m_cnt = 0; m_retries = 0; m_broken = 0; m_total = '0;
      end else if (!m_broken) begin
        if (seg_sent) begin
          m_armed = 1; m_cnt = 0; m_retries = 0;
        end else if (ack_rcvd) begin
          m_armed = 0; m_cnt = 0; m_retries = 0;
        end else if (m_armed && unit_tick) begin
          if (m_cnt + 1 >= int'(timeout)) begin
            m_cnt = 0;
            if (m_retries >= int'(max_retry)) begin
              m_broken = 1; m_armed = 0;
            end else begin
              m_resend = 1; m_retries++; m_total = m_total + 1;
            end
          end else begin
            m_cnt++;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 resend vs model", {31'd0, resend}, {31'd0, m_resend});
      chk("R5 broken vs model", {31'd0, broken}, {31'd0, m_broken});
      chk("R7 total vs model", total, m_total);
    end
  end

  // drive one cycle of inputs, return after the next falling edge
  task automatic cyc(input bit o, input bit s, input bit a, input bit t);
    #1;
    open_req = o; seg_sent = s; ack_rcvd = a; unit_tick = t;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 0; open_req = 0; seg_sent = 0; ack_rcvd = 0; unit_tick = 0;
    timeout = 16'd3; max_retry = 8'd2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 resend after reset", {31'd0, resend}, 32'd0);
    chk("R1 broken after reset", {31'd0, broken}, 32'd0);
    chk("R1 total after reset", total, 32'd0);

    // idle ticks and acks do nothing
    ticks(5);
    cyc(0, 0, 1, 1);
    chk("R2 idle no resend", {31'd0, resend}, 32'd0);
    chk("R2 idle total", total, 32'd0);

    // expiry after exactly timeout ticks
    cyc(0, 1, 0, 0);
    ticks(2);
    chk("R3 no resend before timeout", {31'd0, resend}, 32'd0);
    ticks(1);
    chk("R3 resend at timeout", {31'd0, resend}, 32'd1);
    cyc(0, 0, 0, 0);
    chk("R3 resend is one cycle", {31'd0, resend}, 32'd0);
    ticks(3);
    chk("R3 second resend", {31'd0, resend}, 32'd1);
    ticks(3);
    chk("R5 broken after budget", {31'd0, broken}, 32'd1);
    chk("R5 no resend on failure", {31'd0, resend}, 32'd0);
    chk("R7 total two", total, 32'd2);

    // broken is sticky
    cyc(0, 1, 0, 0);
    ticks(8);
    cyc(0, 0, 1, 0);
    chk("R6 still broken", {31'd0, broken}, 32'd1);
    chk("R6 total held", total, 32'd2);

    // open clears everything; timer stays idle
    cyc(1, 0, 0, 0);
    chk("R8 broken cleared", {31'd0, broken}, 32'd0);
    chk("R8 total cleared", total, 32'd0);
    ticks(6);
    chk("R8 idle after open", total, 32'd0);

    // ack stops the timer
    cyc(0, 1, 0, 0);
    ticks(2);
    cyc(0, 0, 1, 0);
    ticks(5);
    chk("R4 ack stops timer", total, 32'd0);

    // ack clears retries: budget 1
    timeout = 16'd2; max_retry = 8'd1;
    cyc(0, 1, 0, 0);
    ticks(2);
    chk("R4 first resend", {31'd0, resend}, 32'd1);
    cyc(0, 0, 1, 0);
    cyc(0, 1, 0, 0);
    ticks(2);
    chk("R4 retries cleared by ack", {31'd0, resend}, 32'd1);
    chk("R4 not broken", {31'd0, broken}, 32'd0);

    // same-cycle ack and expiring tick
    cyc(0, 1, 0, 0);
    ticks(1);
    cyc(0, 0, 1, 1);
    chk("R4 collision suppresses resend", {31'd0, resend}, 32'd0);

    // restart while armed
    timeout = 16'd4; max_retry = 8'd2;
    cyc(0, 1, 0, 0);
    ticks(3);
    cyc(0, 1, 0, 0);
    chk("R9 no resend after restart", {31'd0, resend}, 32'd0);
    ticks(3);
    chk("R9 count restarted", {31'd0, resend}, 32'd0);
    ticks(1);
    chk("R9 resend after full timeout", {31'd0, resend}, 32'd1);

    // budget zero
    max_retry = 8'd0;
    cyc(0, 1, 0, 0);
    ticks(4);
    chk("R5 budget zero fails", {31'd0, broken}, 32'd1);
    cyc(1, 0, 0, 0);

    // timeout zero acts as one
    timeout = 16'd0; max_retry = 8'd3;
    cyc(0, 1, 0, 0);
    ticks(1);
    chk("R3 timeout zero", {31'd0, resend}, 32'd1);
    cyc(1, 0, 0, 0);

    // mixed stream against the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) begin
        timeout   = 16'($urandom_range(0, 5));
        max_retry = 8'($urandom_range(0, 3));
      end
      cyc(($urandom_range(0, 199) == 0), ($urandom_range(0, 19) == 0),
          ($urandom_range(0, 24) == 0), ($urandom_range(0, 2) == 0));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule